// File: doc/BRIEF.md
# Audio Sample Level Violation Monitor

This block watches a stream of audio samples that arrive already in parallel form, one per valid cycle, each carrying a time-slot number between 0 and 31. Only the top byte of each sample is presented. The block treats that byte as a two's-complement value and takes its magnitude, so positive and negative peaks are judged alike. It then compares the magnitude against a 7-bit programmable ceiling. Whenever the magnitude is above the ceiling, the bit for the sample's slot is set in a 32-bit report word and stays set.

Software samples the report word and pulses a read strobe in the same cycle. The strobe empties the whole word at the next clock edge, so each read returns every slot that went over its limit since the previous read. The comparison is never gated. A small two-state controller tracks whether the report word is empty (`ST_CLEAR`) or holds at least one bit (`ST_STICKY`). The transitions are: `ST_CLEAR -> ST_STICKY` on any violation, `ST_STICKY -> ST_CLEAR` on a read with no violation in the same cycle, and every other case stays in the current state.

Top module: `lvlmon_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the report word is all zero.
- R2: A sample sets its slot bit only when the byte's magnitude is strictly greater than the ceiling. A magnitude equal to or below the ceiling leaves the word unchanged.
- R3: A negative byte is judged by its magnitude. For example, 0xF6 (−10) violates a ceiling of 9 and does not violate a ceiling of 10.
- R4: Byte 0x80 has magnitude 128, so it sets its slot bit for every ceiling value from 0 to 127.
- R5: A violating sample in slot s sets bit s of the report word (bit 0 is slot 0) one clock edge after the valid cycle. No other bit changes.
- R6: Set bits are sticky. Without a read they stay set through later non-violating samples and through violations in other slots.
- R7: A read strobe with no violation in the same cycle clears all 32 bits at the next edge. The word seen during the strobe cycle is the value the read returns.
- R8: When a read and a violation in slot s fall in the same cycle, the word after the edge holds only bit s.
- R9: A cycle with the valid strobe low changes nothing, whatever values the byte, slot and ceiling inputs carry.
- R10: With a ceiling of 0, every nonzero byte violates and byte 0x00 never does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_byte_i | input | 8 | Top byte of the sample, two's complement |
| smp_slot_i | input | 5 | Time-slot number of the sample |
| max_lvl_i | input | 7 | Ceiling on the magnitude, 0 to 127 |
| rd_stb_i | input | 1 | Read strobe; clears the report word at the next edge |
| report_o | output | 32 | Sticky violation bits, one per slot |

## Verification
The bench aims directly at the comparison boundary: it drives magnitudes equal to the ceiling and one above it, for both signs. A design that used `>=`, or that compared the raw signed byte, would set bits on the equal case or miss the negative peaks. The byte 0x80 is driven against a ceiling of 127. A magnitude that wrapped to zero or was cut to 7 bits would fail to flag it. The bench also checks that a read coinciding with a violation keeps only the new bit, because a design that let the clear take priority would lose that bit. It checks that an invalid cycle carrying a large byte leaves the word untouched.

// File: rtl/lvlmon_pkg.sv
package lvlmon_pkg;

    localparam int unsigned LVL_BYTE_W = 8;
    localparam int unsigned LVL_SLOTS  = 32;

    typedef enum logic [0:0] {
        ST_CLEAR  = 1'b0,
        ST_STICKY = 1'b1
    } rpt_state_e;

endpackage

// File: rtl/lvlmon_mag.sv
module lvlmon_mag #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned THR_W = BYTE_W - 1
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [THR_W-1:0]  ceiling_i,
    output logic              over_o
);
    logic [BYTE_W-1:0] mag;

    // Negating in BYTE_W bits turns the most negative value into 2**(BYTE_W-1),
    // which is exactly the wanted magnitude.
    always_comb begin
        if (byte_i[BYTE_W-1]) begin
            mag = (~byte_i) + 1'b1;
        end else begin
            mag = byte_i;
        end
    end

    always_comb begin
        over_o = (mag > {1'b0, ceiling_i});
    end

endmodule

// File: rtl/lvlmon_slot_dec.sv
module lvlmon_slot_dec #(
    parameter int unsigned SLOTS = 32,
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              hit_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [SLOTS-1:0]  hit_vec_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign hit_vec_o[g] = hit_i && (slot_i == SLOT_W'(g));
    end

endmodule

// File: rtl/lvlmon_report.sv
module lvlmon_report
    import lvlmon_pkg::*;
#(
    parameter int unsigned SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] hit_vec_i,
    input  logic             rd_stb_i,
    output logic [SLOTS-1:0] report_o
);
    rpt_state_e       state_q, state_d;
    logic [SLOTS-1:0] bits_q, bits_d;
    logic             any_hit;

    assign any_hit = |hit_vec_i;

    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        unique case (state_q)
            ST_CLEAR: begin
                bits_d = hit_vec_i;
                if (any_hit) begin
                    state_d = ST_STICKY;
                end
            end
            ST_STICKY: begin
                bits_d = (rd_stb_i ? '0 : bits_q) | hit_vec_i;
                if (rd_stb_i && !any_hit) begin
                    state_d = ST_CLEAR;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
        end
    end

    always_comb begin
        report_o = bits_q;
    end

endmodule

// File: rtl/lvlmon_top.sv
module lvlmon_top
    import lvlmon_pkg::*;
#(
    parameter int unsigned BYTE_W = LVL_BYTE_W,
    parameter int unsigned SLOTS  = LVL_SLOTS,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned THR_W  = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld_i,
    input  logic [BYTE_W-1:0] smp_byte_i,
    input  logic [SLOT_W-1:0] smp_slot_i,
    input  logic [THR_W-1:0]  max_lvl_i,
    input  logic              rd_stb_i,
    output logic [SLOTS-1:0]  report_o
);
    logic             over;
    logic [SLOTS-1:0] hit_vec;

    lvlmon_mag #(.BYTE_W(BYTE_W)) u_mag (
        .byte_i    (smp_byte_i),
        .ceiling_i (max_lvl_i),
        .over_o    (over)
    );

    lvlmon_slot_dec #(.SLOTS(SLOTS)) u_dec (
        .hit_i     (smp_vld_i && over),
        .slot_i    (smp_slot_i),
        .hit_vec_o (hit_vec)
    );

    lvlmon_report #(.SLOTS(SLOTS)) u_rpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec_i (hit_vec),
        .rd_stb_i  (rd_stb_i),
        .report_o  (report_o)
    );

endmodule

// File: rtl/lvlmon_chk.sv
module lvlmon_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned SLOTS  = 32,
    localparam int unsigned SLOT_W = $clog2(SLOTS),
    localparam int unsigned THR_W  = BYTE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld_i,
    input logic [BYTE_W-1:0] smp_byte_i,
    input logic [SLOT_W-1:0] smp_slot_i,
    input logic [THR_W-1:0]  max_lvl_i,
    input logic              rd_stb_i,
    input logic [SLOTS-1:0]  report_o
);
    localparam logic [BYTE_W-1:0] MOST_NEG = {1'b1, {(BYTE_W-1){1'b0}}};

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (report_o == '0)); // R1

    AST_MOST_NEG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && smp_byte_i == MOST_NEG) |=> report_o[$past(smp_slot_i)]); // R4

    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> ((report_o & $past(report_o)) == $past(report_o))); // R6

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !smp_vld_i) |=> (report_o == '0)); // R7

    AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && smp_vld_i) |=> ($countones(report_o) <= 1)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld_i && !rd_stb_i) |=> $stable(report_o)); // R9

endmodule

bind lvlmon_top lvlmon_chk #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/lvlmon_top_tb_top.sv
`timescale 1ns/1ps
module lvlmon_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_vld_i;
    logic [7:0]  smp_byte_i;
    logic [4:0]  smp_slot_i;
    logic [6:0]  max_lvl_i;
    logic        rd_stb_i;
    logic [31:0] report_o;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    lvlmon_top dut_i (.*);

    function automatic int unsigned mag_of(input logic [7:0] b);
        int v;
        v = b[7] ? int'(b) - 256 : int'(b);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [31:0] next_model(input logic [31:0] cur, input logic vld,
            input logic [7:0] b, input logic [4:0] s, input logic [6:0] thr, input logic rd);
        logic [31:0] n;
        n = rd ? 32'h0 : cur;
        if (vld && mag_of(b) > int'(thr)) n[s] = 1'b1;
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (report_o !== exp) begin
            n_errors++;
            $display("FAIL %s: report=%08h expected=%08h", req, report_o, exp);
        end
    endtask

    // Called at a negative edge: drive, cross one rising edge, check at the next negative edge.
    task automatic cycle(input string req, input logic vld, input logic [7:0] b,
            input logic [4:0] s, input logic [6:0] thr, input logic rd);
        smp_vld_i = vld; smp_byte_i = b; smp_slot_i = s; max_lvl_i = thr; rd_stb_i = rd;
        model = next_model(model, vld, b, s, thr, rd);
        @(negedge clk);
        check(req, model);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; smp_vld_i = 1'b1; smp_byte_i = 8'h80; smp_slot_i = 5'd3;
        max_lvl_i = 7'd0; rd_stb_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 32'h0);
        rst_n = 1'b1;
        cycle("R1", 1'b0, 8'h00, 5'd0, 7'd0, 1'b0);

        // R2 boundary, positive
        cycle("R2", 1'b1, 8'd40, 5'd1, 7'd40, 1'b0);
        cycle("R2", 1'b1, 8'd41, 5'd1, 7'd40, 1'b0);
        // R3 negative byte 0xF6 = -10
        cycle("R3", 1'b1, 8'hF6, 5'd2, 7'd10, 1'b0);
        cycle("R3", 1'b1, 8'hF6, 5'd2, 7'd9, 1'b0);
        // R4 most negative byte against top ceiling
        cycle("R4", 1'b1, 8'h80, 5'd31, 7'd127, 1'b0);
        cycle("R4", 1'b1, 8'h7F, 5'd30, 7'd127, 1'b0);
        // R5 slot 0 mapping
        cycle("R5", 1'b1, 8'h7F, 5'd0, 7'd5, 1'b0);
        // R6 stickiness under quiet samples and other slots
        cycle("R6", 1'b1, 8'h01, 5'd1, 7'd100, 1'b0);
        cycle("R6", 1'b1, 8'h90, 5'd17, 7'd3, 1'b0);
        // R9 invalid cycle with a huge byte
        cycle("R9", 1'b0, 8'h80, 5'd9, 7'd0, 1'b0);
        // R7 read clears all
        cycle("R7", 1'b0, 8'h00, 5'd0, 7'd0, 1'b1);
        // R8 read coinciding with a violation
        cycle("R6", 1'b1, 8'h70, 5'd5, 7'd1, 1'b0);
        cycle("R8", 1'b1, 8'h70, 5'd12, 7'd1, 1'b1);
        cycle("R7", 1'b0, 8'h00, 5'd0, 7'd0, 1'b1);
        // R10 ceiling zero
        cycle("R10", 1'b1, 8'h00, 5'd6, 7'd0, 1'b0);
        cycle("R10", 1'b1, 8'hFF, 5'd7, 7'd0, 1'b0);
        cycle("R10", 1'b1, 8'h01, 5'd8, 7'd0, 1'b0);

        // Constrained random run, biased toward the ceiling boundary and 0x80
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] thr;
            logic [7:0] b;
            int unsigned sel;
            thr = 7'($urandom);
            sel = $urandom % 8;
            if (sel == 0)      b = 8'h80;
            else if (sel == 1) b = 8'(thr);
            else if (sel == 2) b = 8'(thr) + 8'd1;
            else if (sel == 3) b = 8'(-int'(thr));
            else if (sel == 4) b = 8'(-int'(thr) - 1);
            else               b = 8'($urandom);
            cycle("R5", ($urandom % 4) != 0, b, 5'($urandom), thr, ($urandom % 10) == 0);
        end

        finish_run();
    end

endmodule